// File: doc/BRIEF.md
# Bit-Sliced Arithmetic-Logic Unit

The block is a purely combinational arithmetic-logic unit whose data width is a parameter, 32 bits by default. It is built from a row of identical one-bit slices. Each slice can complement either operand bit before use. It then delivers one of four values: the AND of the two bits, their OR, the bit of a full-adder sum, or a pass-through "less" bit. A ripple carry links the slices from the least significant bit upward.

A 4-bit control word sets the operation. Bit 0 complements operand A. Bit 1 complements operand B and also serves as the carry into the lowest slice, so complementing B produces a two's-complement subtraction. Bits [3:2] pick the slice output.

For set-less-than, the adder sum of the most significant slice is routed back to the "less" input of slice 0. The "less" inputs of all other slices are tied low. The block reports the result vector, the carry leaving the top slice and a flag that marks an all-zero result.

Top module: `bitslice_alu`

## Requirements
- R1: When op_ctrl[0] is 1, every slice uses the bitwise complement of opnd_a in place of opnd_a, for all four result selections and for the adder.
- R2: When op_ctrl[1] is 1, every slice uses the complement of opnd_b, and the carry into bit 0 is 1. When op_ctrl[1] is 0, that carry is 0.
- R3: op_ctrl[3:2] selects the output of each slice: 00 gives the AND of the possibly complemented operands, 01 gives their OR, 10 gives the adder sum, and 11 gives the slice's less input.
- R4: With op_ctrl = 1000, {carry_out, res} equals opnd_a + opnd_b computed to W+1 bits.
- R5: With op_ctrl = 1010, res equals opnd_a - opnd_b modulo 2^W, and carry_out is 1 exactly when opnd_a >= opnd_b as unsigned values.
- R6: With op_ctrl = 1110, res[0] equals bit W-1 of (opnd_a - opnd_b) modulo 2^W, and res[W-1:1] are all 0. No correction for signed overflow is applied.
- R7: With op_ctrl = 0011, res equals the bitwise NOR of opnd_a and opnd_b.
- R8: zero_flag is 1 exactly when every bit of res is 0.
- R9: carry_out is always the carry leaving the top adder slice, whichever result op_ctrl[3:2] selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| op_ctrl | input | 4 | Bit 0 complements A, bit 1 complements B and sets the carry-in, bits [3:2] select the result |
| res | output | W | Result vector |
| carry_out | output | 1 | Carry from the most significant slice |
| zero_flag | output | 1 | 1 when res is all zeros |

## Verification
The checker's assertions are immediate and assume that opnd_a, opnd_b and op_ctrl hold steady while the ripple chain settles, because each check compares finished outputs against the current inputs. The bench meets this by changing inputs only on the falling clock edge and reading outputs just after the following rising edge. All 16 control encodings are applied to every operand pair. The pairs include zero, all ones, the most negative value, equal operands and random values, so the unsigned borrow boundary and the sign-bit boundary are both reached.

// File: rtl/bitslice_alu_pkg.sv
package bitslice_alu_pkg;
    localparam int CTRL_W     = 4;
    localparam int INV_A_BIT  = 0;
    localparam int INV_B_BIT  = 1;
    localparam int SEL_LO_BIT = 2;

    typedef enum logic [1:0] {
        PICK_AND  = 2'b00,
        PICK_OR   = 2'b01,
        PICK_SUM  = 2'b10,
        PICK_LESS = 2'b11
    } pick_e;
endpackage

// File: rtl/bitslice_alu_slice.sv
module bitslice_alu_slice
    import bitslice_alu_pkg::*;
(
    input  logic              bit_a,
    input  logic              bit_b,
    input  logic              carry_in,
    input  logic              less_in,
    input  logic [CTRL_W-1:0] ctrl,
    output logic              bit_out,
    output logic              carry_nx,
    output logic              sum_bit
);
    logic  eff_a;
    logic  eff_b;
    pick_e pick;

    assign eff_a    = ctrl[INV_A_BIT] ? ~bit_a : bit_a;
    assign eff_b    = ctrl[INV_B_BIT] ? ~bit_b : bit_b;
    assign sum_bit  = eff_a ^ eff_b ^ carry_in;
    assign carry_nx = (eff_a & eff_b) | (carry_in & (eff_a ^ eff_b));
    assign pick     = pick_e'(ctrl[SEL_LO_BIT +: 2]);

    always_comb begin
        unique case (pick)
            PICK_AND:  bit_out = eff_a & eff_b;
            PICK_OR:   bit_out = eff_a | eff_b;
            PICK_SUM:  bit_out = sum_bit;
            PICK_LESS: bit_out = less_in;
            default:   bit_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/bitslice_alu_zero.sv
module bitslice_alu_zero #(
    parameter int W = 32
) (
    input  logic [W-1:0] vec,
    output logic         all_clear
);
    assign all_clear = (vec == '0);
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import bitslice_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]      opnd_a,
    input  logic [W-1:0]      opnd_b,
    input  logic [CTRL_W-1:0] op_ctrl,
    output logic [W-1:0]      res,
    output logic              carry_out,
    output logic              zero_flag
);
    localparam int MSB = W - 1;

    logic [W:0]   carry_chain;
    logic [W-1:0] less_vec;
    logic [W-1:0] sum_vec;

    assign carry_chain[0] = op_ctrl[INV_B_BIT];

    generate
        for (genvar i = 0; i < W; i++) begin : g_slice
            if (i == 0) begin : g_lsb
                assign less_vec[i] = sum_vec[MSB];
            end else begin : g_upper
                assign less_vec[i] = 1'b0;
            end
            bitslice_alu_slice u_slice (
                .bit_a    (opnd_a[i]),
                .bit_b    (opnd_b[i]),
                .carry_in (carry_chain[i]),
                .less_in  (less_vec[i]),
                .ctrl     (op_ctrl),
                .bit_out  (res[i]),
                .carry_nx (carry_chain[i+1]),
                .sum_bit  (sum_vec[i])
            );
        end
    endgenerate

    assign carry_out = carry_chain[W];

    bitslice_alu_zero #(.W(W)) u_zero (
        .vec       (res),
        .all_clear (zero_flag)
    );
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [3:0]   op_ctrl,
    input logic [W-1:0] res,
    input logic         carry_out,
    input logic         zero_flag
);
    always_comb begin
        if (op_ctrl == 4'b0000)
            AST_AND_PICK: assert (res == (opnd_a & opnd_b)); // R3
        if (op_ctrl == 4'b1000)
            AST_ADD_WIDE: assert ({carry_out, res} == ({1'b0, opnd_a} + {1'b0, opnd_b})); // R4
        if (op_ctrl == 4'b1010)
            AST_SUB_BORROW: assert ((res == W'(opnd_a - opnd_b)) && (carry_out == (opnd_a >= opnd_b))); // R5
        if (op_ctrl == 4'b1110)
            AST_SLT_UPPER_CLEAR: assert (res[W-1:1] == '0); // R6
        if (op_ctrl == 4'b0011)
            AST_NOR_BITS: assert (res == ~(opnd_a | opnd_b)); // R7
        if (op_ctrl == 4'b1010 && opnd_a == opnd_b)
            AST_EQUAL_ZERO: assert (zero_flag && carry_out); // R8
    end
endmodule

bind bitslice_alu bitslice_alu_chk #(.W(W)) u_chk (.*);

// File: tb/bitslice_alu_bench.sv
module bitslice_alu_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [3:0]   op_ctrl = '0;
    logic [W-1:0] res;
    logic         carry_out;
    logic         zero_flag;
    int           n_checks = 0;
    int           n_fails = 0;

    always #2 clk = ~clk;

    bitslice_alu #(.W(W)) u_bitslice_alu (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .op_ctrl(op_ctrl),
        .res(res), .carry_out(carry_out), .zero_flag(zero_flag)
    );

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'b1000: return "R4";
            4'b1010: return "R5";
            4'b1110: return "R6";
            4'b0011: return "R7";
            4'b0000, 4'b0100: return "R3";
            default: return (c[0] ? "R1" : (c[1] ? "R2" : "R9"));
        endcase
    endfunction

    task automatic run_one(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] c);
        logic [W-1:0] ea, eb, exp_r;
        logic [W:0]   wide;
        logic         exp_z;
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_ctrl = c;
        ea = c[0] ? ~a : a;
        eb = c[1] ? ~b : b;
        wide = {1'b0, ea} + {1'b0, eb} + {{W{1'b0}}, c[1]};
        case (c[3:2])
            2'b00: exp_r = ea & eb;
            2'b01: exp_r = ea | eb;
            2'b10: exp_r = wide[W-1:0];
            default: exp_r = {{(W-1){1'b0}}, wide[W-1]};
        endcase
        exp_z = (exp_r == '0);
        @(posedge clk); #1;
        n_checks++;
        if (res !== exp_r || carry_out !== wide[W] || zero_flag !== exp_z) begin
            n_fails++;
            $display("FAIL %s (R8 zero, R9 carry) ctrl=%b a=%h b=%h: got res=%h c=%b z=%b, want res=%h c=%b z=%b",
                     tag_of(c), c, a, b, res, carry_out, zero_flag, exp_r, wide[W], exp_z);
        end
    endtask

    task automatic sweep(input logic [W-1:0] a, input logic [W-1:0] b);
        for (int k = 0; k < 16; k++) run_one(a, b, 4'(k));
    endtask

    initial begin
        #800000;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R8: all-zero inputs under AND give an all-zero result with the zero flag set
        run_one('0, '0, 4'b0000);
        sweep('0, '0);
        sweep('1, '1);
        sweep('1, 32'h1);                 // R4 carry out of the top bit
        sweep(32'h8000_0000, 32'h1);      // R6 most negative value below one
        sweep(32'h1, 32'h8000_0000);
        sweep(32'h8000_0000, 32'h8000_0000);
        sweep(32'h1234_5678, 32'h1234_5678); // R5 equal operands
        sweep(32'h0000_0005, 32'h0000_0007); // R5 borrow case
        sweep(32'h7FFF_FFFF, 32'hFFFF_FFFF);
        for (int i = 0; i < 200; i++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom();
            rb = (i % 10 == 0) ? ra : $urandom();
            sweep(ra, rb);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule